// File: doc/BRIEF.md
# Interrupt Pending and Enable Controller

This block is the interrupt control unit of a small 8-bit microcontroller core. It keeps a pending flag and an enable bit for each of five sources: an external pin, an idle timer, a serial shifter, and two timer events labelled A and B. It also keeps one global enable. Hardware event pulses set the pending flags. Software reads, sets and clears the flags, and sets the enables, through two byte-wide registers. Each register has a write strobe with write data, and a read data bus.

The external pin first passes through a synchronizer. An edge detector then follows, and a control input selects the polarity of the edge it looks for. The block drives one registered request line to the core. That line is high when any source has its pending flag and its enable set, and the global enable is also set. The core handles vectoring and priority. The status byte also holds two arithmetic flags (half-carry and carry) and a read-only shifter-busy bit, so its layout matches what the core's software expects.

Top module: `ipe_ctrl`

## Requirements
- R1: After reset, every stored bit is 0 and `irq` is 0. `st_rdata` shows only the live `shift_busy` value on bit 2, and `ic_rdata` reads 0x00.
- R2: The status byte layout, bit 7 down to bit 0, is: half-carry, carry, timer-A pending, timer-A enable, external pending, shifter busy (read-only, equal to `shift_busy`), external enable, global enable. A write stores every bit except bit 2.
- R3: The control byte layout, bit 7 down to bit 0, is: reserved, port wakeup enable, idle pending, idle enable, shifter pending, shifter enable, timer-B pending, timer-B enable. Bit 7 always reads 0. `port_wake_en` mirrors bit 6.
- R4: A one-cycle pulse on `evt_tmra`, `evt_idle`, `evt_shift` or `evt_tmrb` sets the matching pending flag at that clock edge. The flag stays set until software changes it.
- R5: A register write stores the written value into each pending flag it covers: 0 clears the flag and 1 sets it. Without a write or an event, a flag holds its value.
- R6: If a hardware set event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R7: `ext_pin` passes through two synchronizer flops. With `ext_fall`=0 a rising edge sets the external pending flag, and with `ext_fall`=1 a falling edge sets it. The flag becomes visible three clock edges after the pin changes. An edge of the other polarity has no effect.
- R8: `irq` rises one clock edge after the global enable and some source's pending flag and enable are all set together. It stays low while the global enable is 0 or while no source has both its flag and enable set.
- R9: `irq` falls one clock edge after the last source with both flag and enable set is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_fall | input | 1 | Edge select: 0 rising, 1 falling |
| evt_tmra | input | 1 | Timer A set pulse |
| evt_idle | input | 1 | Idle timer set pulse |
| evt_shift | input | 1 | Shifter set pulse |
| evt_tmrb | input | 1 | Timer B set pulse |
| shift_busy | input | 1 | Shifter busy status |
| st_we | input | 1 | Status byte write strobe |
| st_wdata | input | 8 | Status byte write data |
| st_rdata | output | 8 | Status byte read data |
| ic_we | input | 1 | Control byte write strobe |
| ic_wdata | input | 8 | Control byte write data |
| ic_rdata | output | 8 | Control byte read data |
| port_wake_en | output | 1 | Port wakeup enable bit |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong flag or enable shows up on the read buses in the first cycle after the edge that should have set it. It shows up on `irq` one edge later. A fault in the gating shows up as a wrong `irq` level one edge after the pending, enable and global-enable combination settles. The bench sweeps every source against every enable and global-enable setting, so a source that is dropped or crossed with another shows at once. A synchronizer or polarity fault shows up as a flag that arrives on the wrong edge count or from the wrong edge.

// File: rtl/ipe_pkg.sv
package ipe_pkg;
  localparam int NSRC = 5;
  // source indices into the pending/enable vectors
  localparam int S_EXT   = 0;
  localparam int S_TMRA  = 1;
  localparam int S_IDLE  = 2;
  localparam int S_SHIFT = 3;
  localparam int S_TMRB  = 4;
  // status byte positions (software decodes these)
  localparam int ST_HC  = 7;
  localparam int ST_C   = 6;
  localparam int ST_TAP = 5;
  localparam int ST_TAE = 4;
  localparam int ST_EXP = 3;
  localparam int ST_BSY = 2;
  localparam int ST_EXE = 1;
  localparam int ST_GIE = 0;
  // control byte positions
  localparam int CT_RSV = 7;
  localparam int CT_PWE = 6;
  localparam int CT_IDP = 5;
  localparam int CT_IDE = 4;
  localparam int CT_SHP = 3;
  localparam int CT_SHE = 2;
  localparam int CT_TBP = 1;
  localparam int CT_TBE = 0;

  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic sw_we, input logic sw_wd);
    return hw_set | (sw_we ? sw_wd : cur);
  endfunction

  function automatic logic irq_want(input logic [NSRC-1:0] pend,
                                    input logic [NSRC-1:0] en,
                                    input logic gie);
    return gie && (|(pend & en));
  endfunction
endpackage

// File: rtl/ipe_edge_det.sv
module ipe_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              sync_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_out;
    end
  end

  assign sync_out = sync_q[STAGES-1];
  assign evt = fall_sel ? (prev_q & ~sync_out) : (~prev_q & sync_out);

  // R7: with a steady polarity, an edge event lasts one cycle only
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (!evt || (fall_sel != $past(fall_sel))));
endmodule

// File: rtl/ipe_flag.sv
module ipe_flag
  import ipe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_we,
  input  logic sw_wd,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= flag_next(q, hw_set, sw_we, sw_wd);
  end

  a_r4_hw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> q);
  a_r5_sw_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !sw_wd && !hw_set) |=> !q);
  a_r5_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !hw_set) |=> (q == $past(q)));
endmodule

// File: rtl/ipe_ctrl.sv
module ipe_ctrl
  import ipe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_pin,
  input  logic       ext_fall,
  input  logic       evt_tmra,
  input  logic       evt_idle,
  input  logic       evt_shift,
  input  logic       evt_tmrb,
  input  logic       shift_busy,
  input  logic       st_we,
  input  logic [7:0] st_wdata,
  output logic [7:0] st_rdata,
  input  logic       ic_we,
  input  logic [7:0] ic_wdata,
  output logic [7:0] ic_rdata,
  output logic       port_wake_en,
  output logic       irq
);
  logic            ext_evt;
  logic [NSRC-1:0] hw_set, sw_we, sw_wd, pend, en;
  logic            hc_q, c_q, gie_q, pwe_q, irq_q;

  ipe_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .fall_sel(ext_fall), .evt(ext_evt));

  // route events and write lanes to each source
  assign hw_set[S_EXT]   = ext_evt;
  assign hw_set[S_TMRA]  = evt_tmra;
  assign hw_set[S_IDLE]  = evt_idle;
  assign hw_set[S_SHIFT] = evt_shift;
  assign hw_set[S_TMRB]  = evt_tmrb;

  assign sw_we[S_EXT]    = st_we;  assign sw_wd[S_EXT]   = st_wdata[ST_EXP];
  assign sw_we[S_TMRA]   = st_we;  assign sw_wd[S_TMRA]  = st_wdata[ST_TAP];
  assign sw_we[S_IDLE]   = ic_we;  assign sw_wd[S_IDLE]  = ic_wdata[CT_IDP];
  assign sw_we[S_SHIFT]  = ic_we;  assign sw_wd[S_SHIFT] = ic_wdata[CT_SHP];
  assign sw_we[S_TMRB]   = ic_we;  assign sw_wd[S_TMRB]  = ic_wdata[CT_TBP];

  for (genvar i = 0; i < NSRC; i++) begin : g_pend
    ipe_flag u_flag (
      .clk(clk), .rst_n(rst_n), .hw_set(hw_set[i]),
      .sw_we(sw_we[i]), .sw_wd(sw_wd[i]), .q(pend[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc_q <= 1'b0; c_q <= 1'b0; gie_q <= 1'b0; pwe_q <= 1'b0;
      en   <= '0;
    end else begin
      if (st_we) begin
        hc_q       <= st_wdata[ST_HC];
        c_q        <= st_wdata[ST_C];
        gie_q      <= st_wdata[ST_GIE];
        en[S_TMRA] <= st_wdata[ST_TAE];
        en[S_EXT]  <= st_wdata[ST_EXE];
      end
      if (ic_we) begin
        pwe_q       <= ic_wdata[CT_PWE];
        en[S_IDLE]  <= ic_wdata[CT_IDE];
        en[S_SHIFT] <= ic_wdata[CT_SHE];
        en[S_TMRB]  <= ic_wdata[CT_TBE];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_want(pend, en, gie_q);
  end

  always_comb begin
    st_rdata         = '0;
    st_rdata[ST_HC]  = hc_q;
    st_rdata[ST_C]   = c_q;
    st_rdata[ST_TAP] = pend[S_TMRA];
    st_rdata[ST_TAE] = en[S_TMRA];
    st_rdata[ST_EXP] = pend[S_EXT];
    st_rdata[ST_BSY] = shift_busy;
    st_rdata[ST_EXE] = en[S_EXT];
    st_rdata[ST_GIE] = gie_q;
    ic_rdata         = '0;
    ic_rdata[CT_PWE] = pwe_q;
    ic_rdata[CT_IDP] = pend[S_IDLE];
    ic_rdata[CT_IDE] = en[S_IDLE];
    ic_rdata[CT_SHP] = pend[S_SHIFT];
    ic_rdata[CT_SHE] = en[S_SHIFT];
    ic_rdata[CT_TBP] = pend[S_TMRB];
    ic_rdata[CT_TBE] = en[S_TMRB];
  end

  assign port_wake_en = pwe_q;
  assign irq          = irq_q;

  a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_q && (pend & en) != '0) |=> irq);
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q || (pend & en) == '0) |=> !irq);
endmodule

// File: tb/ipe_ctrl_tb.sv
`timescale 1ns/1ps
module ipe_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_pin = 1'b0, ext_fall = 1'b0;
  logic evt_tmra = 1'b0, evt_idle = 1'b0, evt_shift = 1'b0, evt_tmrb = 1'b0;
  logic shift_busy = 1'b0;
  logic st_we = 1'b0, ic_we = 1'b0;
  logic [7:0] st_wdata = '0, ic_wdata = '0, st_rdata, ic_rdata;
  logic port_wake_en, irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_fall(ext_fall),
    .evt_tmra(evt_tmra), .evt_idle(evt_idle), .evt_shift(evt_shift),
    .evt_tmrb(evt_tmrb), .shift_busy(shift_busy),
    .st_we(st_we), .st_wdata(st_wdata), .st_rdata(st_rdata),
    .ic_we(ic_we), .ic_wdata(ic_wdata), .ic_rdata(ic_rdata),
    .port_wake_en(port_wake_en), .irq(irq));

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_st(logic [7:0] d);
    st_we = 1'b1; st_wdata = d; step(); st_we = 1'b0;
  endtask
  task automatic wr_ic(logic [7:0] d);
    ic_we = 1'b1; ic_wdata = d; step(); ic_we = 1'b0;
  endtask

  // status byte: 5 tmrA pend, 4 tmrA en, 3 ext pend, 1 ext en, 0 gie
  // control byte: 5 idle pend, 4 idle en, 3 shift pend, 2 shift en, 1 tmrB pend, 0 tmrB en
  function automatic logic [7:0] st_en_byte(int s, logic e, logic g);
    logic [7:0] b = '0;
    b[0] = g;
    if (s == 0) b[1] = e;
    if (s == 1) b[4] = e;
    return b;
  endfunction
  function automatic logic [7:0] ic_en_byte(int s, logic e);
    logic [7:0] b = '0;
    if (s == 2) b[4] = e;
    if (s == 3) b[2] = e;
    if (s == 4) b[0] = e;
    return b;
  endfunction
  function automatic logic pend_of(int s, logic [7:0] st, logic [7:0] ic);
    case (s)
      0: return st[3];
      1: return st[5];
      2: return ic[5];
      3: return ic[3];
      default: return ic[1];
    endcase
  endfunction

  task automatic pulse(int s);
    case (s)
      1: evt_tmra = 1'b1;
      2: evt_idle = 1'b1;
      3: evt_shift = 1'b1;
      default: evt_tmrb = 1'b1;
    endcase
    step();
    evt_tmra = 1'b0; evt_idle = 1'b0; evt_shift = 1'b0; evt_tmrb = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    step(); step(); rst_n = 1'b1; step();
    // R1 reset state
    chk("R1 st", st_rdata, 8'h00);
    chk("R1 ic", ic_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 layout, busy read-only
    wr_st(8'hFF);
    chk("R2 st all", st_rdata, 8'hFB);
    step();
    chk("R8 irq from sw-set flags", {7'b0, irq}, 8'h01);
    shift_busy = 1'b1; #1;
    chk("R2 busy live", st_rdata, 8'hFF);
    wr_st(8'h00);
    chk("R2 st cleared", st_rdata, 8'h04);
    step();
    chk("R9 irq low", {7'b0, irq}, 8'h00);
    shift_busy = 1'b0;
    wr_st(8'hC0);
    chk("R2 hc c only", st_rdata, 8'hC0);
    wr_st(8'h00);

    // R3 control layout, reserved bit
    wr_ic(8'hFF);
    chk("R3 ic rsv zero", ic_rdata, 8'h7F);
    chk("R3 wake", {7'b0, port_wake_en}, 8'h01);
    wr_ic(8'h80);
    chk("R3 ic only rsv", ic_rdata, 8'h00);
    chk("R3 wake off", {7'b0, port_wake_en}, 8'h00);

    // R4/R5/R8/R9 sweep over source, enable, global enable
    for (int s = 0; s < 5; s++)
      for (int e = 0; e < 2; e++)
        for (int g = 0; g < 2; g++) begin
          logic [7:0] sb, ib;
          sb = st_en_byte(s, e[0], g[0]);
          ib = ic_en_byte(s, e[0]);
          wr_ic(ib); wr_st(sb);
          step();
          chk("R8 idle before set", {7'b0, irq}, 8'h00);
          if (s == 0) wr_st(sb | 8'h08);  // R5 software set
          else        pulse(s);           // R4 event set
          chk($sformatf("R4 pend src%0d", s),
              {7'b0, pend_of(s, st_rdata, ic_rdata)}, 8'h01);
          step();
          chk($sformatf("R8 irq src%0d e%0d g%0d", s, e, g),
              {7'b0, irq}, {7'b0, e[0] & g[0]});
          step();
          chk("R4 pend held", {7'b0, pend_of(s, st_rdata, ic_rdata)}, 8'h01);
          wr_ic(ib); wr_st(sb);  // R5 clear by writing 0
          chk("R5 pend cleared", {7'b0, pend_of(s, st_rdata, ic_rdata)}, 8'h00);
          step();
          chk("R9 irq dropped", {7'b0, irq}, 8'h00);
        end

    // R6 hardware set beats software clear
    wr_st(8'h00); wr_ic(8'h00);
    evt_tmra = 1'b1; st_we = 1'b1; st_wdata = 8'h00;
    evt_idle = 1'b1; ic_we = 1'b1; ic_wdata = 8'h00;
    step();
    evt_tmra = 1'b0; evt_idle = 1'b0; st_we = 1'b0; ic_we = 1'b0;
    chk("R6 tmrA wins", st_rdata, 8'h20);
    chk("R6 idle wins", ic_rdata, 8'h20);
    wr_st(8'h00); wr_ic(8'h00);

    // R7 edge polarity and latency
    for (int pol = 0; pol < 2; pol++) begin
      ext_fall = pol[0];
      ext_pin = pol[0];
      repeat (5) step();
      wr_st(8'h00);
      chk("R7 clear", st_rdata, 8'h00);
      ext_pin = ~pol[0];
      step(); step();
      chk($sformatf("R7 pol%0d not yet", pol), {7'b0, st_rdata[3]}, 8'h00);
      step();
      chk($sformatf("R7 pol%0d set", pol), {7'b0, st_rdata[3]}, 8'h01);
      wr_st(8'h00);
      ext_pin = pol[0];  // opposite edge
      repeat (5) step();
      chk($sformatf("R7 pol%0d wrong edge", pol), {7'b0, st_rdata[3]}, 8'h00);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule